// File: doc/BRIEF.md
# Dual-Mode Integer Square Root

This unit takes an unsigned binary integer and returns two integer approximations of its square root at once. The first is the floor of the root, meaning the root truncated toward zero. The second is the root rounded to the nearest integer. Both results come from the same input word and settle together.

There is no clock, no state and no handshake. Both outputs are pure functions of the present input and follow it after a fixed logic delay. The floor is built one result bit at a time, most significant first, by a chain of trial-square comparisons. A final comparison then decides whether the rounded result steps up by one.

A neighbour that needs the rounded result sees a word one bit wider than the floor. The extra bit is needed because rounding can carry past the largest floor value.

Top module: `isqrt_dual`

## Requirements
- R1: With the default 8-bit input, the floor output is 4 bits wide and the rounded output is 5 bits wide. Input 255 gives a floor of 15.
- R2: The floor output is the largest integer r for which r*r is not greater than the input.
- R3: The rounded output is the integer n for which (2n-1)^2 <= 4*input < (2n+1)^2, and 0 for input 0. Equivalently, it is floor+1 when the input exceeds floor*floor+floor, and floor otherwise.
- R4: When the input is a perfect square (0, 1, 4, 9, ..., 225), both outputs equal its exact root.
- R5: The rounded output is either equal to the floor output or exactly one greater.
- R6: The following input values give these (floor, rounded) pairs: 3 gives (1,2), 7 gives (2,3), 8 gives (2,3), 13 gives (3,4), 15 gives (3,4).
- R7: Inputs 241 through 255 give a rounded value of 16, which uses the top bit of the rounded output. Input 240 gives a rounded value of 15.
- R8: Both outputs depend only on the current input. The same input gives the same results whatever value was applied before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | IN_W (8) | Unsigned radicand |
| root_floor | output | (IN_W+1)/2 (4) | Square root truncated toward zero |
| root_near | output | (IN_W+1)/2+1 (5) | Square root rounded to nearest integer |

## Verification
The bench builds the block with its default 8-bit input. This keeps the input space at 256 values, so every input can be applied and compared with a reference that searches for the root in the bench. The sweep is followed by seeded random values and by directed jumps between the extremes. These reach the perfect squares, the 241 to 255 band where the rounded result carries into its fifth bit, and history-independence after large input steps.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

  // Result width of an integer root for a radicand of in_w bits
  function automatic int floor_width(input int in_w);
    return (in_w + 1) / 2;
  endfunction

endpackage

// File: rtl/isqrt_trial_stage.sv
module isqrt_trial_stage #(
  parameter int IN_W = 8,
  parameter int FL_W = 4,
  parameter int BIT  = 0
) (
  input  logic [IN_W-1:0] radicand,
  input  logic [FL_W-1:0] root_in,
  output logic [FL_W-1:0] root_out
);

  localparam int SQ_W = 2 * FL_W;

  logic [FL_W-1:0] cand;
  logic [SQ_W-1:0] cand_sq;
  logic [SQ_W-1:0] rad_ext;

  // Try setting this result bit; keep it if the square still fits
  always_comb begin
    cand     = root_in | (FL_W'(1) << BIT);
    cand_sq  = SQ_W'(cand) * SQ_W'(cand);
    rad_ext  = SQ_W'(radicand);
    root_out = (cand_sq <= rad_ext) ? cand : root_in;
  end

endmodule

// File: rtl/isqrt_round.sv
module isqrt_round #(
  parameter int IN_W = 8,
  parameter int FL_W = 4
) (
  input  logic [IN_W-1:0] radicand,
  input  logic [FL_W-1:0] root_floor,
  output logic [FL_W:0]   root_near
);

  localparam int TH_W = 2 * FL_W + 1;

  logic [TH_W-1:0] thresh;
  logic            step_up;

  // The midpoint (r+0.5)^2 = r*r + r + 0.25, so integer compare against r*r + r
  always_comb begin
    thresh    = TH_W'(root_floor) * TH_W'(root_floor) + TH_W'(root_floor);
    step_up   = TH_W'(radicand) > thresh;
    root_near = {1'b0, root_floor} + (FL_W+1)'(step_up);
  end

endmodule

// File: rtl/isqrt_dual.sv
module isqrt_dual #(
  parameter  int IN_W = 8,
  localparam int FL_W = isqrt_pkg::floor_width(IN_W)
) (
  input  logic [IN_W-1:0] din,
  output logic [FL_W-1:0] root_floor,
  output logic [FL_W:0]   root_near
);

  // chain[k] holds the partial root once bits FL_W-1 down to k are decided
  logic [FL_W-1:0] chain [FL_W+1];

  assign chain[FL_W] = '0;

  for (genvar g = FL_W - 1; g >= 0; g--) begin : g_stage
    isqrt_trial_stage #(
      .IN_W (IN_W),
      .FL_W (FL_W),
      .BIT  (g)
    ) u_stage (
      .radicand (din),
      .root_in  (chain[g+1]),
      .root_out (chain[g])
    );
  end

  assign root_floor = chain[0];

  isqrt_round #(
    .IN_W (IN_W),
    .FL_W (FL_W)
  ) u_round (
    .radicand   (din),
    .root_floor (root_floor),
    .root_near  (root_near)
  );

endmodule

// File: rtl/isqrt_dual_checker.sv
module isqrt_dual_checker #(
  parameter int IN_W = 8,
  parameter int FL_W = 4
) (
  input logic [IN_W-1:0] din,
  input logic [FL_W-1:0] root_floor,
  input logic [FL_W:0]   root_near
);

  longint x, f, n;

  always_comb begin
    x = longint'(din);
    f = longint'(root_floor);
    n = longint'(root_near);
    if (!$isunknown({din, root_floor, root_near})) begin
      AST_FLOOR_FITS: assert (f * f <= x) else $error("floor too large");       // R2
      AST_FLOOR_TIGHT: assert ((f + 1) * (f + 1) > x) else $error("floor too small"); // R2
      AST_NEAR_BAND: assert ((n == 0) ? (4 * x < 1) : (((2*n-1)*(2*n-1) <= 4*x) && (4*x < (2*n+1)*(2*n+1)))) else $error("rounded root off"); // R3
      AST_NEAR_STEP: assert ((n == f) || (n == f + 1)) else $error("rounded minus floor out of range"); // R5
      AST_SQUARE_EXACT: assert ((f * f != x) || (n == f)) else $error("perfect square rounded away"); // R4
    end
  end

endmodule

bind isqrt_dual isqrt_dual_checker #(
  .IN_W (IN_W),
  .FL_W (FL_W)
) u_chk (
  .din        (din),
  .root_floor (root_floor),
  .root_near  (root_near)
);

// File: tb/isqrt_dual_bench.sv
module isqrt_dual_bench;

  localparam int IN_W = 8;
  localparam int FL_W = (IN_W + 1) / 2;

  logic            clk;
  logic            rst_n;
  logic [IN_W-1:0] din;
  logic [FL_W-1:0] root_floor;
  logic [FL_W:0]   root_near;

  int n_checks;
  int n_fail;
  int cycles;

  isqrt_dual #(.IN_W(IN_W)) u_isqrt_dual (
    .din        (din),
    .root_floor (root_floor),
    .root_near  (root_near)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int ref_floor(input int x);
    int r = 0;
    for (int k = 0; k * k <= x; k++) r = k;
    return r;
  endfunction

  function automatic int ref_near(input int x);
    int n = 0;
    for (int k = 1; (2*k-1)*(2*k-1) <= 4*x; k++) n = k;
    return n;
  endfunction

  task automatic check(input string tag, input int act, input int exp, input int x);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s din=%0d actual=%0d expected=%0d", tag, x, act, exp);
    end
  endtask

  task automatic apply(input int x);
    @(negedge clk);
    din = IN_W'(x);
    #1;
    check("R2", int'(root_floor), ref_floor(x), x);
    check("R3", int'(root_near), ref_near(x), x);
    check("R5", int'(root_near) - int'(root_floor) inside {0, 1} ? 1 : 0, 1, x);
    if (ref_floor(x) * ref_floor(x) == x) begin
      check("R4 floor", int'(root_floor), ref_floor(x), x);
      check("R4 near", int'(root_near), ref_floor(x), x);
    end
  endtask

  task automatic pair(input string tag, input int x, input int ef, input int en);
    @(negedge clk);
    din = IN_W'(x);
    #1;
    check(tag, int'(root_floor), ef, x);
    check(tag, int'(root_near), en, x);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int seed_dummy;
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    din      = '0;
    seed_dummy = $urandom(32'h5EED_1234);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // Reset-time output with zero input
    check("R2 reset", int'(root_floor), 0, 0);
    check("R3 reset", int'(root_near), 0, 0);
    // R1: port widths
    check("R1 floor width", $bits(root_floor), 4, 0);
    check("R1 near width", $bits(root_near), 5, 0);
    pair("R1 max", 255, 15, 16);
    // R6: sample values
    pair("R6", 3, 1, 2);
    pair("R6", 7, 2, 3);
    pair("R6", 8, 2, 3);
    pair("R6", 13, 3, 4);
    pair("R6", 15, 3, 4);
    // R4: small perfect squares
    pair("R4", 0, 0, 0);
    pair("R4", 1, 1, 1);
    pair("R4", 4, 2, 2);
    pair("R4", 9, 3, 3);
    // R7: top band of rounded output
    pair("R7", 240, 15, 15);
    for (int v = 241; v <= 255; v++) pair("R7", v, 15, 16);
    // Exhaustive sweep
    for (int v = 0; v < 256; v++) apply(v);
    // Seeded random
    for (int i = 0; i < 400; i++) apply(int'($urandom_range(255, 0)));
    // R8: same input after different predecessors
    pair("R8", 255, 15, 16);
    pair("R8", 120, 10, 11);
    pair("R8", 0, 0, 0);
    pair("R8", 120, 10, 11);
    pair("R8", 143, 11, 12);
    pair("R8", 120, 10, 11);
    finish_run();
  end

endmodule